// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Victim Buffer

This block is a read-only, direct-mapped line cache backed by a small fully associative victim buffer. The victim buffer keeps lines that were pushed out of the main array by conflicts, so that a few addresses that alias to the same set can still be served without a trip to the next level. Each lookup probes the main array and every victim entry in the same cycle. A line lives in at most one of the two structures. On a victim hit, the requested line moves into the main set and the line it replaces takes over the freed victim slot.

On a miss in both structures, the block raises a line request toward the next level and stalls the lookup port until the line arrives. It then installs the line in the main set and retires the previous valid occupant into the victim buffer, using a least-recently-used choice when the buffer is full. A one-cycle flush input drops every line in both structures.

Top module: `dm_victim_cache`

## Requirements
- R1: A lookup accepted while `req_ready` is high that hits the main array gives `resp_valid`=1, `resp_hit`=1 and `resp_victim`=0 in the next cycle, and `req_ready` stays high.
- R2: A lookup that hits the victim buffer drops `req_ready` for one cycle with no response. The response (`resp_hit`=1, `resp_victim`=1) comes two cycles after acceptance.
- R3: No line is ever present in both structures, and no line occupies two victim entries. After a victim hit the requested line hits in the main array, and the line it replaced hits in the victim buffer.
- R4: On a miss in both structures, `fill_req` rises in the cycle after acceptance. `fill_addr` carries the request address with the word offset bits zeroed. `fill_req` stays high and `req_ready` stays low until `fill_valid` is sampled high. The response then follows in the next cycle with `resp_hit`=0.
- R5: On a refill, a valid line previously held in the target set is placed in the victim buffer. An empty set places nothing, so no victim entry is disturbed.
- R6: Each victim insertion uses the lowest-numbered free entry if one exists. Otherwise it replaces the entry that was least recently written. Every write of a valid line into an entry makes that entry the most recent.
- R7: With default parameters, address bits [1:0] select the word, bits [5:2] the set and bits [15:6] the tag. Word k of a line sits at bits [32k+31:32k] of `fill_data`, and `resp_data` returns the selected word.
- R8: A `flush` pulse in an idle cycle invalidates every line in both structures by the next cycle, so every later lookup misses until lines are refilled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all lines in both structures |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup this cycle |
| req_addr | input | ADDR_W | Word address of the lookup |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Response was served from a stored line |
| resp_victim | output | 1 | Response was served from the victim buffer |
| resp_data | output | WORD_W | Requested word |
| fill_req | output | 1 | Line request to next level |
| fill_addr | output | ADDR_W | Line-aligned address of the requested line |
| fill_valid | input | 1 | Next level delivers the line |
| fill_data | input | WORD_W*LINE_WORDS | Returned line, word 0 in the low bits |

## Verification
If the internal state is wrong, the first sign is the wrong response kind on the very next lookup of an affected line. Examples are a refill request where a victim hit was due, a one-cycle hit where a two-cycle swap should occur, or a hit after a flush. A swap that loses the displaced line stays hidden until that line is asked for again. At that point the bench expects a victim hit and sees a refill request instead. A bad replacement choice appears the same way, one lookup after the wrong eviction. A bench model of both structures predicts the outcome of each lookup, and the directed sequences keep the distance between a fault and the lookup that exposes it short.

// File: rtl/dm_victim_cache.sv
module dm_victim_cache #(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 32,
  parameter int SETS       = 16,
  parameter int LINE_WORDS = 4,
  parameter int VICT       = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [ADDR_W-1:0]            req_addr,
  output logic                         resp_valid,
  output logic                         resp_hit,
  output logic                         resp_victim,
  output logic [WORD_W-1:0]            resp_data,
  output logic                         fill_req,
  output logic [ADDR_W-1:0]            fill_addr,
  input  logic                         fill_valid,
  input  logic [WORD_W*LINE_WORDS-1:0] fill_data
);
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LA_W   = ADDR_W - OFF_W;
  localparam int LINE_W = WORD_W * LINE_WORDS;
  localparam int VI_W   = $clog2(VICT);

  typedef enum logic [1:0] {ST_IDLE, ST_SWAP, ST_FILL} state_t;
  state_t st;

  logic [SETS-1:0]   m_valid;
  logic [TAG_W-1:0]  m_tag  [SETS];
  logic [LINE_W-1:0] m_data [SETS];
  logic [VICT-1:0]   v_valid;
  logic [LA_W-1:0]   v_la   [VICT];
  logic [LINE_W-1:0] v_data [VICT];
  logic [VI_W-1:0]   v_age  [VICT];

  logic [ADDR_W-1:0] p_addr;
  logic [VI_W-1:0]   p_vidx;

  wire [TAG_W-1:0] q_tag = req_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] q_idx = req_addr[OFF_W +: IDX_W];
  wire [OFF_W-1:0] q_off = req_addr[OFF_W-1:0];
  wire [TAG_W-1:0] p_tag = p_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] p_idx = p_addr[OFF_W +: IDX_W];
  wire [OFF_W-1:0] p_off = p_addr[OFF_W-1:0];

  assign req_ready = (st == ST_IDLE);
  assign fill_req  = (st == ST_FILL);
  assign fill_addr = {p_tag, p_idx, {OFF_W{1'b0}}};

  wire accept = req_valid && req_ready;
  wire m_hit  = m_valid[q_idx] && (m_tag[q_idx] == q_tag);

  logic [VICT-1:0] v_match;
  for (genvar g = 0; g < VICT; g++) begin : g_probe
    assign v_match[g] = v_valid[g] && (v_la[g] == {q_tag, q_idx});
  end
  wire v_any = |v_match;

  logic [VI_W-1:0] v_hidx, v_slot;
  always_comb begin
    v_hidx = '0;
    for (int i = 0; i < VICT; i++)
      if (v_match[i]) v_hidx = VI_W'(i);
  end

  always_comb begin
    v_slot = '0;
    for (int i = 0; i < VICT; i++)
      if (v_age[i] == VI_W'(VICT - 1)) v_slot = VI_W'(i);
    for (int i = VICT - 1; i >= 0; i--)
      if (!v_valid[i]) v_slot = VI_W'(i);
  end

  wire fill_done = (st == ST_FILL) && fill_valid;
  wire m_wr      = (st == ST_SWAP) || fill_done;
  wire v_wr      = (st == ST_SWAP) || (fill_done && m_valid[p_idx]);
  wire v_keep    = m_valid[p_idx];
  wire [VI_W-1:0]   v_wr_idx  = (st == ST_SWAP) ? p_vidx : v_slot;
  wire [LINE_W-1:0] m_wr_data = (st == ST_SWAP) ? v_data[p_vidx] : fill_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      m_valid     <= '0;
      v_valid     <= '0;
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      resp_victim <= 1'b0;
      for (int i = 0; i < VICT; i++) v_age[i] <= VI_W'(i);
    end else begin
      resp_valid <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          p_addr <= req_addr;
          p_vidx <= v_hidx;
          if (m_hit) begin
            resp_valid  <= 1'b1;
            resp_hit    <= 1'b1;
            resp_victim <= 1'b0;
            resp_data   <= m_data[q_idx][q_off*WORD_W +: WORD_W];
          end else if (v_any) begin
            st <= ST_SWAP;
          end else begin
            st <= ST_FILL;
          end
        end
        ST_SWAP: begin
          st          <= ST_IDLE;
          resp_valid  <= 1'b1;
          resp_hit    <= 1'b1;
          resp_victim <= 1'b1;
          resp_data   <= v_data[p_vidx][p_off*WORD_W +: WORD_W];
        end
        ST_FILL: if (fill_valid) begin
          st          <= ST_IDLE;
          resp_valid  <= 1'b1;
          resp_hit    <= 1'b0;
          resp_victim <= 1'b0;
          resp_data   <= fill_data[p_off*WORD_W +: WORD_W];
        end
        default: st <= ST_IDLE;
      endcase

      if (m_wr) begin
        m_valid[p_idx] <= 1'b1;
        m_tag[p_idx]   <= p_tag;
        m_data[p_idx]  <= m_wr_data;
      end

      if (v_wr) begin
        v_valid[v_wr_idx] <= v_keep;
        v_la[v_wr_idx]    <= {m_tag[p_idx], p_idx};
        v_data[v_wr_idx]  <= m_data[p_idx];
        if (v_keep)
          for (int i = 0; i < VICT; i++)
            if (VI_W'(i) == v_wr_idx) v_age[i] <= '0;
            else if (v_age[i] < v_age[v_wr_idx]) v_age[i] <= v_age[i] + 1'b1;
      end

      if (flush) begin
        m_valid <= '0;
        v_valid <= '0;
      end
    end
  end
endmodule

// File: rtl/dm_victim_cache_chk.sv
module dm_victim_cache_chk #(
  parameter int SETS = 16,
  parameter int VICT = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            req_valid,
  input logic            req_ready,
  input logic            resp_valid,
  input logic            resp_hit,
  input logic            resp_victim,
  input logic            fill_req,
  input logic            fill_valid,
  input logic            m_hit,
  input logic            v_any,
  input logic [VICT-1:0] v_match,
  input logic [SETS-1:0] m_valid,
  input logic [VICT-1:0] v_valid
);
  wire acc = req_valid && req_ready;

  a_r1_main_hit_next: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && m_hit) |=> (resp_valid && resp_hit && !resp_victim && req_ready));

  a_r2_victim_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && v_any) |=> (!req_ready && !resp_valid));

  a_r2_victim_done: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && v_any) |=> ##1 (resp_valid && resp_hit && resp_victim));

  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_hit && v_any));

  a_r3_victim_unique: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(v_match));

  a_r4_miss_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !m_hit && !v_any) |=> fill_req);

  a_r4_stall: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !req_ready);

  a_r4_fill_done: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && fill_valid) |=> (resp_valid && !resp_hit && !fill_req));

  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (m_valid == '0 && v_valid == '0));
endmodule

bind dm_victim_cache dm_victim_cache_chk #(.SETS(SETS), .VICT(VICT)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_victim(resp_victim),
  .fill_req(fill_req), .fill_valid(fill_valid),
  .m_hit(m_hit), .v_any(v_any), .v_match(v_match),
  .m_valid(m_valid), .v_valid(v_valid)
);

// File: tb/dm_victim_cache_tb_top.sv
module dm_victim_cache_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         flush = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [15:0]  req_addr = '0;
  logic         resp_valid, resp_hit, resp_victim;
  logic [31:0]  resp_data;
  logic         fill_req;
  logic [15:0]  fill_addr;
  logic         fill_valid = 1'b0;
  logic [127:0] fill_data = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dm_victim_cache dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_victim(resp_victim),
    .resp_data(resp_data), .fill_req(fill_req), .fill_addr(fill_addr),
    .fill_valid(fill_valid), .fill_data(fill_data)
  );

  bit         bm_valid [16];
  logic [9:0] bm_tag   [16];
  bit         bv_valid [4];
  logic [13:0] bv_la   [4];
  int         bv_age   [4];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(int tag, int idx, int off);
    return 16'((tag << 6) | (idx << 2) | off);
  endfunction

  function automatic logic [31:0] memw(logic [13:0] la, int k);
    return (32'(la) * 32'h0001_0003) ^ (32'(k) * 32'h1111_0101) ^ 32'h5EED_1234;
  endfunction

  function automatic logic [127:0] line_of(logic [15:0] a);
    logic [127:0] l;
    for (int k = 0; k < 4; k++) l[k*32 +: 32] = memw(a[15:2], k);
    return l;
  endfunction

  function automatic int model_kind(logic [15:0] a);
    int ix = int'(a[5:2]);
    if (bm_valid[ix] && bm_tag[ix] == a[15:6]) return 0;
    for (int i = 0; i < 4; i++) if (bv_valid[i] && bv_la[i] == a[15:2]) return 1;
    return 2;
  endfunction

  function automatic void model_touch(int e);
    int old = bv_age[e];
    for (int i = 0; i < 4; i++)
      if (i == e) bv_age[i] = 0;
      else if (bv_age[i] < old) bv_age[i]++;
  endfunction

  function automatic int model_slot();
    int s = 0;
    for (int i = 0; i < 4; i++) if (bv_age[i] == 3) s = i;
    for (int i = 3; i >= 0; i--) if (!bv_valid[i]) s = i;
    return s;
  endfunction

  function automatic void model_update(int kind, logic [15:0] a);
    int ix = int'(a[5:2]);
    int e = 0;
    if (kind == 1) begin
      for (int i = 0; i < 4; i++) if (bv_valid[i] && bv_la[i] == a[15:2]) e = i;
      if (bm_valid[ix]) begin
        bv_la[e] = {bm_tag[ix], a[5:2]};
        model_touch(e);
      end else bv_valid[e] = 1'b0;
    end else if (kind == 2 && bm_valid[ix]) begin
      e = model_slot();
      bv_valid[e] = 1'b1;
      bv_la[e] = {bm_tag[ix], a[5:2]};
      model_touch(e);
    end
    bm_valid[ix] = 1'b1;
    bm_tag[ix] = a[15:6];
  endfunction

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk(req_ready, "R8", "ready after flush", 32'(req_ready), 1);
    for (int i = 0; i < 16; i++) bm_valid[i] = 1'b0;
    for (int i = 0; i < 4; i++) bv_valid[i] = 1'b0;
  endtask

  task automatic do_lookup(input logic [15:0] a, input int expk, input string rq);
    int k = model_kind(a);
    int w;
    if (expk >= 0) chk(k == expk, rq, "predicted kind", 32'(k), 32'(expk));
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (k == 0) begin
      chk(resp_valid && resp_hit && !resp_victim, "R1", "main hit response",
          {29'd0, resp_valid, resp_hit, resp_victim}, 32'b110);
      chk(req_ready, "R1", "ready during hit", 32'(req_ready), 1);
      chk(resp_data == memw(a[15:2], int'(a[1:0])), "R7", "hit data", resp_data,
          memw(a[15:2], int'(a[1:0])));
    end else if (k == 1) begin
      chk(!req_ready && !resp_valid, "R2", "swap stall",
          {30'd0, req_ready, resp_valid}, 0);
      @(negedge clk);
      chk(resp_valid && resp_hit && resp_victim, "R2", "victim hit response",
          {29'd0, resp_valid, resp_hit, resp_victim}, 32'b111);
      chk(resp_data == memw(a[15:2], int'(a[1:0])), "R7", "victim data", resp_data,
          memw(a[15:2], int'(a[1:0])));
    end else begin
      chk(fill_req && !req_ready, "R4", "refill request", {30'd0, fill_req, req_ready}, 32'b10);
      chk(fill_addr == {a[15:2], 2'b00}, "R4", "refill address", 32'(fill_addr),
          32'({a[15:2], 2'b00}));
      w = int'($urandom % 3);
      for (int j = 0; j < w; j++) begin
        @(negedge clk);
        chk(fill_req && !req_ready && !resp_valid, "R4", "refill hold",
            {29'd0, fill_req, req_ready, resp_valid}, 32'b100);
      end
      fill_valid = 1'b1;
      fill_data = line_of(a);
      @(negedge clk);
      fill_valid = 1'b0;
      fill_data = '0;
      chk(resp_valid && !resp_hit && !fill_req, "R4", "refill response",
          {29'd0, resp_valid, resp_hit, fill_req}, 32'b100);
      chk(resp_data == memw(a[15:2], int'(a[1:0])), "R7", "refill data", resp_data,
          memw(a[15:2], int'(a[1:0])));
    end
    model_update(k, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4177));
    for (int i = 0; i < 16; i++) bm_valid[i] = 1'b0;
    for (int i = 0; i < 4; i++) begin bv_valid[i] = 1'b0; bv_age[i] = i; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !resp_valid && !fill_req, "R1", "reset state",
        {29'd0, req_ready, resp_valid, fill_req}, 32'b100);

    // R4, R1, R5, R2, R3 basic swap sequence in set 0
    do_lookup(mk(1, 0, 2), 2, "R4");
    do_lookup(mk(1, 0, 3), 0, "R1");
    do_lookup(mk(2, 0, 1), 2, "R5");
    do_lookup(mk(1, 0, 0), 1, "R2");
    do_lookup(mk(1, 0, 1), 0, "R3");
    do_lookup(mk(2, 0, 3), 1, "R3");

    // R7 top-of-range field positions
    do_lookup(mk(1023, 15, 3), 2, "R7");
    do_lookup(mk(1023, 15, 0), 0, "R7");

    // R8 flush drops main and victim lines
    do_flush();
    do_lookup(mk(2, 0, 0), 2, "R8");
    do_lookup(mk(1, 0, 0), 2, "R8");

    // R5 empty set displaces nothing
    do_flush();
    for (int t = 1; t <= 5; t++) do_lookup(mk(t, 1, t % 4), 2, "R5");
    do_lookup(mk(0, 5, 0), 2, "R5");
    for (int t = 1; t <= 4; t++) do_lookup(mk(t, 1, 0), 1, "R5");

    // R6 least recently written entry is replaced
    do_flush();
    for (int t = 1; t <= 6; t++) do_lookup(mk(t, 2, 1), 2, "R6");
    do_lookup(mk(2, 2, 2), 1, "R6");
    do_lookup(mk(1, 2, 2), 2, "R6");

    // random mix with heavy set conflicts
    for (int n = 0; n < 400; n++) begin
      if ($urandom % 50 == 0) do_flush();
      do_lookup(mk(int'($urandom % 6), int'($urandom % 3), int'($urandom % 4)), -1, "R3");
    end

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule